// File: doc/BRIEF.md
# Serial Flash Slave Front-End

This block is the serial front-end of a small serial flash memory. It shifts instruction, address and data bytes in from the serial data input and shifts status or data bytes out on the serial data output. It handles the chip-select frame, output enable, a pause input that freezes a transaction mid-byte, and a rule that keeps the device deaf after power-up until select has been seen high and then low. Decoding of instructions, the storage array and write protection are handled by the command layer that sits behind it.

All four serial pins (clock, select, data in, pause) pass through a common synchronizer into the system clock domain, so the block runs from one fast system clock. Edges of the serial clock are detected there. The command layer sees a one-cycle strobe with each received byte, a pulse at the start and at the end of every frame, and it supplies the next byte to send on `tx_byte`. The output driver is given as a data bit plus an enable, and a pad cell builds the tri-state from those two.

Top module: `spi_flash_frontend`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `spi_miso_oe`, `rx_byte_vld`, `frame_start` and `frame_end` are 0.
- R2: After reset, a select that is already low is ignored: no byte is received, no frame pulse is raised and `spi_miso_oe` stays 0 until `spi_cs_n` has been seen high and then low.
- R3: Data-in bits are taken on rising serial-clock edges, most significant bit first. After every eighth such bit, `rx_byte_vld` is high for exactly one system cycle with the assembled byte on `rx_byte`.
- R4: Data-out bits change on falling serial-clock edges, most significant bit first. Bit 7 of `tx_byte` as sampled at the select edge is on `spi_miso` before the first rising edge. Each later byte is the `tx_byte` value sampled at the falling edge that follows the eighth rising edge of the previous byte.
- R5: Frames work both with the serial clock idling low (mode 0) and with it idling high (mode 3). In mode 3 the first falling edge does not advance the output.
- R6: `spi_cs_n` high disables the output (`spi_miso_oe` = 0), ends the frame, drops a partly received byte and raises `frame_end` for one cycle. The next frame starts again at bit 0.
- R7: While `spi_hold_n` is low during a frame, `spi_miso_oe` is 0 and serial-clock and data-in activity is ignored. When `spi_hold_n` goes high again, the transfer continues at the same bit.
- R8: A low level on `spi_hold_n` while `spi_cs_n` is high has no effect. A frame that follows is received and sent normally.
- R9: `frame_start` is high for one cycle when a select edge that counts is seen.
- R10: A change on a serial pin that is in place before system clock edge k shows on the outputs after edge k + SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| tx_byte | input | BYTE_W | Next byte to send, from the command layer |
| rx_byte | output | BYTE_W | Last complete byte received |
| rx_byte_vld | output | 1 | One-cycle strobe for `rx_byte` |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |
| frame_end | output | 1 | One-cycle pulse when select is released |

## Verification
Every registered output is due SYNC_STAGES + 1 system edges after the pin change that causes it: SYNC_STAGES synchronizer flops and then one output register. The bench model feeds pin samples through a queue of that depth and updates its state at each rising system edge. Every output is compared at the falling edge that follows, so each compare reads a settled value from that cycle. The serial-level checks sample `spi_miso` and `spi_miso_oe` eight system cycles after the last pin change, which is well past that latency. Received bytes and frame pulses are counted once the frame has closed.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

   // Serial pins bundled so that one synchronizer carries them with equal delay.
   typedef struct packed {
      logic cs_n;
      logic sck;
      logic mosi;
      logic hold_n;
   } spi_pins_t;

   localparam int PINS_W = $bits(spi_pins_t);

   // Select resets low so that a select already low at power-up shows no falling edge.
   localparam spi_pins_t PINS_RST = '{cs_n: 1'b0, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int             W      = 4,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RSTVAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("spi_fe_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_badw
      $error("spi_fe_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= RSTVAL;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
   parameter int W = 8,
   localparam int CW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rise,
   input  logic          bit_in,
   output logic [CW-1:0] cnt,
   output logic          vld,
   output logic [W-1:0]  data
);
   localparam logic [CW-1:0] LAST = CW'(W-1);

   logic [W-1:0] shreg;
   logic [W-1:0] shnext;

   assign shnext = {shreg[W-2:0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
         vld   <= 1'b0;
         data  <= '0;
      end else begin
         vld <= 1'b0;
         if (clr) begin
            cnt <= '0;
         end else if (rise) begin
            shreg <= shnext;
            if (cnt == LAST) begin
               cnt  <= '0;
               vld  <= 1'b1;
               data <= shnext;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R3: a completed byte strobe never lasts two cycles
   p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         fall,
   input  logic         boundary,
   input  logic [W-1:0] din,
   output logic         dout
);
   logic [W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shreg <= '0;
      else if (load)       shreg <= din;
      else if (fall) begin
         if (boundary)     shreg <= din;
         else              shreg <= {shreg[W-2:0], 1'b0};
      end
   end

   assign dout = shreg[W-1];
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   input  logic              spi_hold_n,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_byte_vld,
   output logic              frame_start,
   output logic              frame_end
);
   import spi_fe_pkg::*;

   localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   if (BYTE_W < 2) begin : g_badw
      $error("spi_flash_frontend: BYTE_W must be at least 2");
   end

   spi_pins_t pins_raw, pins_s;
   logic      cs_q, sck_q, in_frame;
   logic      cs_fall, sel, go, sck_rise, sck_fall;
   logic [CW-1:0] rx_cnt;

   assign pins_raw = '{cs_n: spi_cs_n, sck: spi_sck, mosi: spi_mosi, hold_n: spi_hold_n};

   spi_fe_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RSTVAL(PINS_RST)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
   );

   // Edge and frame qualification
   assign cs_fall  = cs_q & ~pins_s.cs_n;
   assign sel      = ~pins_s.cs_n & (in_frame | cs_fall);
   assign go       = sel & pins_s.hold_n;
   assign sck_rise = go &  pins_s.sck & ~sck_q;
   assign sck_fall = go & ~pins_s.sck &  sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q        <= PINS_RST.cs_n;
         sck_q       <= PINS_RST.sck;
         in_frame    <= 1'b0;
         frame_start <= 1'b0;
         frame_end   <= 1'b0;
         spi_miso_oe <= 1'b0;
      end else begin
         cs_q        <= pins_s.cs_n;
         sck_q       <= pins_s.sck;
         frame_start <= cs_fall;
         frame_end   <= in_frame & pins_s.cs_n;
         spi_miso_oe <= go;
         if (cs_fall)          in_frame <= 1'b1;
         else if (pins_s.cs_n) in_frame <= 1'b0;
      end
   end

   spi_fe_rx #(.W(BYTE_W)) i_rx (
      .clk(clk), .rst_n(rst_n),
      .clr(pins_s.cs_n | cs_fall), .rise(sck_rise), .bit_in(pins_s.mosi),
      .cnt(rx_cnt), .vld(rx_byte_vld), .data(rx_byte)
   );

   spi_fe_tx #(.W(BYTE_W)) i_tx (
      .clk(clk), .rst_n(rst_n),
      .load(cs_fall), .fall(sck_fall), .boundary(rx_cnt == '0),
      .din(tx_byte), .dout(spi_miso)
   );

   // R6: released select turns the output off on the next cycle
   p_oe_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pins_s.cs_n |=> !spi_miso_oe);
   // R6: released select leaves the bit counter at zero
   p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pins_s.cs_n |=> (rx_cnt == '0));
   // R7: a pause holds the receive position
   p_hold_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_s.hold_n && !pins_s.cs_n && !cs_fall) |=> $stable(rx_cnt));
   // R7: a pause holds the output bit
   p_hold_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_s.hold_n && !cs_fall) |=> $stable(spi_miso));
   // R2: the output is driven only inside an accepted frame
   p_oe_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_miso_oe |-> in_frame);
   // R9: the start pulse lasts one cycle
   p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
endmodule

// File: tb/test_spi_flash_frontend.sv
module test_spi_flash_frontend;
   localparam int S    = 2;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, hold_n = 1'b1;
   logic miso, miso_oe, rx_vld, fs, fe;
   logic [7:0] tx_byte = 8'h00, rx_byte;

   always #2.5 clk = ~clk;

   spi_flash_frontend #(.BYTE_W(8), .SYNC_STAGES(S)) i_spi_flash_frontend (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .rx_byte_vld(rx_vld), .frame_start(fs), .frame_end(fe)
   );

   int nchk = 0, nerr = 0;
   int fs_cnt = 0, fe_cnt = 0;
   bit oe_seen = 0;
   logic [7:0] got[$];
   logic [7:0] mo[$];
   logic [7:0] txq[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model: pin history queue, behavioural state, updated per rising edge
   logic [3:0] pq[$];
   bit m_csq, m_sckq, m_inf, m_oe, m_vld, m_fs, m_fe;
   int m_cnt, m_rx, m_rxb, m_tx;

   always @(posedge clk) begin
      if (!rst_n) begin
         pq.delete();
         for (int i = 0; i < S; i++) pq.push_back(4'b0001);
         m_csq = 0; m_sckq = 0; m_inf = 0; m_oe = 0; m_vld = 0; m_fs = 0; m_fe = 0;
         m_cnt = 0; m_rx = 0; m_rxb = 0; m_tx = 0;
      end else begin
         logic [3:0] cur;
         bit c, s, m, h, csf, go, r, f;
         cur = pq.pop_front();
         pq.push_back({cs_n, sck, mosi, hold_n});
         c = cur[3]; s = cur[2]; m = cur[1]; h = cur[0];
         csf = m_csq && !c;
         go  = !c && (m_inf || csf) && h;
         r   = go && s && !m_sckq;
         f   = go && !s && m_sckq;
         m_fs  = csf;
         m_fe  = m_inf && c;
         m_oe  = go;
         m_vld = r && (m_cnt == 7);
         if (m_vld) m_rxb = ((m_rx << 1) | m) & 255;
         if (csf)    m_tx = tx_byte;
         else if (f) m_tx = (m_cnt == 0) ? int'(tx_byte) : ((m_tx << 1) & 255);
         if (r) m_rx = ((m_rx << 1) | m) & 255;
         if (c || csf) m_cnt = 0;
         else if (r)   m_cnt = (m_cnt + 1) % 8;
         if (csf)    m_inf = 1;
         else if (c) m_inf = 0;
         m_csq = c; m_sckq = s;
      end
   end

   // R10: every output compared with the model each cycle
   always @(negedge clk) begin
      if (rst_n) begin
         chk(miso_oe == m_oe && rx_vld == m_vld && fs == m_fs && fe == m_fe,
             "R10 model", {miso_oe, rx_vld, fs, fe}, {m_oe, m_vld, m_fs, m_fe});
         if (m_vld) chk(rx_byte == m_rxb[7:0], "R10 rx_byte", rx_byte, m_rxb);
         if (m_oe)  chk(miso == m_tx[7], "R10 miso", miso, m_tx[7]);
         if (rx_vld) got.push_back(rx_byte);
         if (fs) fs_cnt++;
         if (fe) fe_cnt++;
         if (miso_oe) oe_seen = 1;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One frame: nbits bits, pause inserted before bit hold_bit (-1 for none)
   task automatic frame(input bit mode3, input int nbits, input int hold_bit, input string tag);
      got.delete(); fs_cnt = 0; fe_cnt = 0;
      tx_byte = txq[0];
      sck = mode3;
      idle(4);
      cs_n = 0;
      idle(HALF);
      for (int k = 0; k < nbits; k++) begin
         int bi = k / 8;
         int bb = 7 - (k % 8);
         sck = 0; mosi = mo[bi][bb];
         idle(HALF);
         if (k == hold_bit) begin
            hold_n = 0;
            idle(5);
            chk(miso_oe == 0, "R7 paused output off", miso_oe, 0);
            sck = 1; mosi = ~mosi; idle(4);
            sck = 0; idle(4);
            mosi = mo[bi][bb]; hold_n = 1;
            idle(HALF);
         end
         chk(miso_oe == 1 && miso == txq[bi][bb], {tag, " R4 out bit"}, {miso_oe, miso}, {1'b1, txq[bi][bb]});
         sck = 1;
         if (k % 8 == 7 && bi + 1 < txq.size()) tx_byte = txq[bi+1];
         idle(HALF);
      end
      if (!mode3) begin sck = 0; idle(HALF); end
      cs_n = 1;
      idle(6);
      chk(miso_oe == 0, "R6 output off after release", miso_oe, 0);
      chk(fs_cnt == 1, "R9 one start pulse", fs_cnt, 1);
      chk(fe_cnt == 1, "R6 one end pulse", fe_cnt, 1);
      chk(got.size() == nbits / 8, {tag, " R3 byte count"}, got.size(), nbits / 8);
      for (int i = 0; i < got.size() && i < mo.size(); i++)
         chk(got[i] == mo[i], {tag, " R3 byte value"}, got[i], mo[i]);
   endtask

   task automatic main;
      // R1 reset state; R2 select already low at power-up
      idle(4);
      chk(miso_oe == 0 && rx_vld == 0 && fs == 0 && fe == 0, "R1 in reset", {miso_oe, rx_vld, fs, fe}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(miso_oe == 0 && rx_vld == 0 && fs == 0 && fe == 0, "R1 after reset", {miso_oe, rx_vld, fs, fe}, 0);
      got.delete(); fs_cnt = 0;
      for (int k = 0; k < 16; k++) begin
         sck = 0; mosi = k[0]; idle(HALF);
         sck = 1; idle(HALF);
      end
      sck = 0; idle(HALF);
      chk(got.size() == 0, "R2 no byte before select edge", got.size(), 0);
      chk(oe_seen == 0, "R2 output stays off", oe_seen, 0);
      chk(fs_cnt == 0, "R2 no start pulse", fs_cnt, 0);
      cs_n = 1; idle(HALF);

      // R5 mode 0, three bytes
      mo = '{8'hA5, 8'h3C, 8'h81}; txq = '{8'hC3, 8'h5A, 8'h01, 8'h00};
      frame(0, 24, -1, "R5 mode0");
      // R5 mode 3, three bytes
      mo = '{8'h0F, 8'hF0, 8'h96}; txq = '{8'h9B, 8'h7E, 8'h80, 8'h00};
      frame(1, 24, -1, "R5 mode3");
      // R7 pause mid-byte, mode 0 and mode 3
      mo = '{8'h6D, 8'hB2}; txq = '{8'hE4, 8'h27, 8'h00};
      frame(0, 16, 11, "R7 mode0");
      mo = '{8'h55, 8'hAA}; txq = '{8'h1F, 8'hF8, 8'h00};
      frame(1, 16, 3, "R7 mode3");
      // R6 abort after 12 bits, then a clean frame from bit 0
      mo = '{8'hD7, 8'h00}; txq = '{8'h44, 8'h99, 8'h00};
      frame(0, 12, -1, "R6 abort");
      mo = '{8'h18}; txq = '{8'hBD, 8'h00};
      frame(0, 8, -1, "R6 restart");
      // R8 pause while deselected has no effect
      got.delete();
      hold_n = 0; idle(4);
      sck = 1; idle(HALF); sck = 0; idle(HALF);
      chk(miso_oe == 0, "R8 output off", miso_oe, 0);
      chk(got.size() == 0, "R8 no byte", got.size(), 0);
      hold_n = 1; idle(HALF);
      mo = '{8'h7A, 8'hC1}; txq = '{8'h2D, 8'hD2, 8'h00};
      frame(1, 16, -1, "R8 after");
   endtask

   initial begin
      fork
         main();
         begin
            repeat (150000) @(posedge clk);
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected finish");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule